// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits between two independent ports, left and right, that share one word array. It watches the address each active port presents. When both ports aim at the same word, it raises a BUSY flag toward the port that arrived second. A port that already holds the word keeps it until its access ends or it moves away. The write of a port whose BUSY is raised is withheld from the array. Read output drive follows each port's own enable, output-enable and direction controls and is never gated by BUSY.

A strap input picks the arbitration role. In master mode the block arbitrates and drives both BUSY outputs. In slave mode it ignores its own arbitration. It takes the two BUSY values from external inputs instead, which are wired from a master's BUSY outputs. Several arrays can then be laid side by side for a wider word, and they all stall the same write. One clock samples both ports. Every output reflects the request sampled at the preceding rising edge.

There is no data path here, so there is no valid/ready interface. All pins are plain level controls and flags.

Top module: `dp_contention_arb`

## Requirements
- R1: After reset, with master mode selected, BUSY, write-go and read-drive outputs of both ports are 0.
- R2: Every output reflects the port requests sampled at the preceding rising clock edge; a request change is not visible before that edge.
- R3: In master mode, if either port is idle (enable 0) or the two addresses differ at a sample, both BUSY outputs are 0 in the following cycle.
- R4: In master mode, when both ports present the same address and neither held that address at the previous sample, the left port wins and right BUSY is 1.
- R5: In master mode, a port that presented the same address at the previous sample while the other port did not wins the contention; the newcomer sees BUSY.
- R6: In master mode, the holding port keeps the word for as long as it stays enabled on the same address, and the other port's BUSY remains 1 throughout.
- R7: In master mode, BUSY falls in the cycle after the sample at which the holding port releases (enable 0) or changes its address.
- R8: In master mode, the two BUSY outputs are never 1 together.
- R9: In slave mode, each BUSY output equals its external BUSY input, and the internal arbitration result has no effect on BUSY or write-go.
- R10: Write-go of a port is 1 exactly when that port sampled enable=1 and write=1 and its effective BUSY (internal in master mode, external in slave mode) is 0.
- R11: Read-drive of a port is 1 exactly when it sampled enable=1, output-enable=1 and write=0, whatever BUSY is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | Strap: 1 = arbitrate internally, 0 = obey external BUSY |
| l_en | input | 1 | Left port enable (1 = access active) |
| l_wr | input | 1 | Left port direction (1 = write, 0 = read) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | AW | Left port word address |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port direction |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | AW | Right port word address |
| l_busy_in | input | 1 | External left BUSY, used in slave mode |
| r_busy_in | input | 1 | External right BUSY, used in slave mode |
| l_busy | output | 1 | Effective left BUSY flag |
| r_busy | output | 1 | Effective right BUSY flag |
| l_wr_go | output | 1 | Left write strobe permitted into the array |
| r_wr_go | output | 1 | Right write strobe permitted into the array |
| l_rd_drive | output | 1 | Left read data output drive enable |
| r_rd_drive | output | 1 | Right read data output drive enable |

## Verification
The bound assertions check the properties that hold at every cycle. BUSY flags are mutually exclusive in master mode. A port whose BUSY is up never gets a write strobe. A sample with no address match clears both flags. A fresh same-cycle collision goes to the left. Read drive follows the sampled controls. Only the bench scenarios show the ownership history. These are the cases where an earlier arrival keeps the word, BUSY persists while the holder waits, BUSY falls after a release or an address move, and slave mode overrides an internal result that would differ.

// File: rtl/dpca_pkg.sv
`timescale 1ns/1ps
package dpca_pkg;
  localparam int PORTS = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    logic en;
    logic wr;
    logic oe;
  } port_ctl_t;
endpackage

// File: rtl/dpca_port_stage.sv
`timescale 1ns/1ps
module dpca_port_stage
  import dpca_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  port_ctl_t     ctl_i,
  input  logic [AW-1:0] addr_i,
  output port_ctl_t     ctl_q,
  output logic          stay_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      addr_q <= '0;
    end else begin
      ctl_q  <= ctl_i;
      addr_q <= addr_i;
    end
  end

  // port remained on the same word since the previous sample
  assign stay_o = ctl_i.en & ctl_q.en & (addr_i == addr_q);
endmodule

// File: rtl/dpca_arbiter.sv
`timescale 1ns/1ps
module dpca_arbiter
  import dpca_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PORTS-1:0]          act_i,
  input  logic [PORTS-1:0][AW-1:0]  addr_i,
  input  logic [PORTS-1:0]          stay_i,
  output logic [PORTS-1:0]          busy_q
);
  owner_e own_q, own_d, win;
  logic   same;

  always_comb begin
    same = act_i[LEFT] & act_i[RIGHT] & (addr_i[LEFT] == addr_i[RIGHT]);
    if (own_q == OWN_RIGHT && stay_i[RIGHT])
      win = OWN_RIGHT;
    else if (own_q == OWN_LEFT && stay_i[LEFT])
      win = OWN_LEFT;
    else if (stay_i[RIGHT] && !stay_i[LEFT])
      win = OWN_RIGHT;
    else
      win = OWN_LEFT;
    own_d = same ? win : OWN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= OWN_NONE;
      busy_q <= '0;
    end else begin
      own_q         <= own_d;
      busy_q[LEFT]  <= (own_d == OWN_RIGHT);
      busy_q[RIGHT] <= (own_d == OWN_LEFT);
    end
  end
endmodule

// File: rtl/dpca_grant.sv
`timescale 1ns/1ps
module dpca_grant
  import dpca_pkg::*;
(
  input  logic                  master_mode,
  input  logic [PORTS-1:0]      busy_int_i,
  input  logic [PORTS-1:0]      busy_ext_i,
  input  port_ctl_t [PORTS-1:0] ctl_q_i,
  output logic [PORTS-1:0]      busy_o,
  output logic [PORTS-1:0]      wr_go_o,
  output logic [PORTS-1:0]      rd_drive_o
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic busy_eff;
    assign busy_eff      = master_mode ? busy_int_i[p] : busy_ext_i[p];
    assign busy_o[p]     = busy_eff;
    assign wr_go_o[p]    = ctl_q_i[p].en & ctl_q_i[p].wr & ~busy_eff;
    assign rd_drive_o[p] = ctl_q_i[p].en & ctl_q_i[p].oe & ~ctl_q_i[p].wr;
  end
endmodule

// File: rtl/dp_contention_arb.sv
`timescale 1ns/1ps
module dp_contention_arb
  import dpca_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic          l_wr,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic          r_wr,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic          l_busy_in,
  input  logic          r_busy_in,
  output logic          l_busy,
  output logic          r_busy,
  output logic          l_wr_go,
  output logic          r_wr_go,
  output logic          l_rd_drive,
  output logic          r_rd_drive
);
  port_ctl_t [PORTS-1:0]         ctl_in, ctl_q;
  logic      [PORTS-1:0][AW-1:0] addr_in;
  logic      [PORTS-1:0]         act, stay, busy_int, busy_ext, busy_v, wr_go_v, rd_v;

  assign ctl_in[LEFT]   = '{en: l_en, wr: l_wr, oe: l_oe};
  assign ctl_in[RIGHT]  = '{en: r_en, wr: r_wr, oe: r_oe};
  assign addr_in[LEFT]  = l_addr;
  assign addr_in[RIGHT] = r_addr;
  assign busy_ext       = {r_busy_in, l_busy_in};

  for (genvar p = 0; p < PORTS; p++) begin : g_stage
    assign act[p] = ctl_in[p].en;
    dpca_port_stage #(.AW(AW)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl_i  (ctl_in[p]),
      .addr_i (addr_in[p]),
      .ctl_q  (ctl_q[p]),
      .stay_o (stay[p])
    );
  end

  dpca_arbiter #(.AW(AW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_i  (act),
    .addr_i (addr_in),
    .stay_i (stay),
    .busy_q (busy_int)
  );

  dpca_grant u_grant (
    .master_mode (master_mode),
    .busy_int_i  (busy_int),
    .busy_ext_i  (busy_ext),
    .ctl_q_i     (ctl_q),
    .busy_o      (busy_v),
    .wr_go_o     (wr_go_v),
    .rd_drive_o  (rd_v)
  );

  assign l_busy     = busy_v[LEFT];
  assign r_busy     = busy_v[RIGHT];
  assign l_wr_go    = wr_go_v[LEFT];
  assign r_wr_go    = wr_go_v[RIGHT];
  assign l_rd_drive = rd_v[LEFT];
  assign r_rd_drive = rd_v[RIGHT];
endmodule

// File: rtl/dpca_checker.sv
`timescale 1ns/1ps
module dpca_checker #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          l_en,
  input logic          l_wr,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic          r_en,
  input logic          r_wr,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_in,
  input logic          r_busy_in,
  input logic          l_busy,
  input logic          r_busy,
  input logic          l_wr_go,
  input logic          r_wr_go,
  input logic          l_rd_drive,
  input logic          r_rd_drive
);
  logic hit;
  assign hit = l_en && r_en && (l_addr == r_addr);

  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> !(l_busy && r_busy)); // R8
  AST_NO_MATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !hit) |=> (!master_mode || (!l_busy && !r_busy))); // R3
  AST_FRESH_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !$past(l_en) && !$past(r_en)) |=> (!master_mode || r_busy)); // R4
  AST_L_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy |-> !l_wr_go); // R10
  AST_R_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy |-> !r_wr_go); // R10
  AST_SLAVE_L_OBEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && l_busy_in) |-> !l_wr_go); // R9
  AST_SLAVE_R_OBEY: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && r_busy_in) |-> !r_wr_go); // R9
  AST_L_RD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_oe && !l_wr) |=> l_rd_drive); // R11
  AST_R_RD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_oe && !r_wr) |=> r_rd_drive); // R11
endmodule

bind dp_contention_arb dpca_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
  .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
  .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
  .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
  .l_busy(l_busy), .r_busy(r_busy), .l_wr_go(l_wr_go), .r_wr_go(r_wr_go),
  .l_rd_drive(l_rd_drive), .r_rd_drive(r_rd_drive)
);

// File: tb/dp_contention_arb_tb.sv
`timescale 1ns/1ps
module dp_contention_arb_tb;
  localparam int AW = 2;
  localparam int NA = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, master_mode = 1'b1;
  logic l_en = 0, l_wr = 0, l_oe = 0, r_en = 0, r_wr = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_in = 0, r_busy_in = 0;
  logic l_busy, r_busy, l_wr_go, r_wr_go, l_rd_drive, r_rd_drive;
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  dp_contention_arb #(.AW(AW)) u_dut (.*);

  // order: l_busy r_busy l_wr_go r_wr_go l_rd_drive r_rd_drive
  function automatic logic [5:0] outs();
    return {l_busy, r_busy, l_wr_go, r_wr_go, l_rd_drive, r_rd_drive};
  endfunction

  task automatic chk(input string req, input logic [5:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs %b, expected %b", req, outs(), exp);
    end
  endtask

  task automatic drv(input logic le, lw, lo, input logic [AW-1:0] la,
                     input logic re, rw, ro, input logic [AW-1:0] ra);
    l_en = le; l_wr = lw; l_oe = lo; l_addr = la;
    r_en = re; r_wr = rw; r_oe = ro; r_addr = ra;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset state", 6'b000000);

    // Sweep A: every fresh request pair after an idle cycle (R3 R4 R10 R11)
    for (int v = 0; v < 256; v++) begin
      logic le, re, lw, rw, lo, ro, rb;
      logic [AW-1:0] la, ra;
      le = v[0]; re = v[1]; lw = v[2]; rw = v[3];
      la = v[5:4]; ra = v[7:6]; lo = la[0]; ro = ra[1];
      drv(0, 0, 0, '0, 0, 0, 0, '0);
      tick();
      chk("R3 idle gives no busy", 6'b000000);
      drv(le, lw, lo, la, re, rw, ro, ra);
      tick();
      rb = le & re & (la == ra);
      chk("R4/R10/R11 fresh pair", {1'b0, rb, le & lw, re & rw & ~rb,
                                    le & lo & ~lw, re & ro & ~rw});
    end

    // Sweep B: right arrives first, left joins, right releases (R2 R5 R6 R7)
    for (int a = 0; a < NA * NA; a++) begin
      logic [AW-1:0] la, ra;
      logic lb;
      la = a[AW-1:0]; ra = a[2*AW-1:AW];
      lb = (la == ra);
      drv(0, 0, 0, '0, 0, 0, 0, '0);
      tick();
      drv(0, 0, 0, '0, 1, 1, 0, ra);
      tick();
      chk("R10 right alone writes", 6'b000100);
      drv(1, 1, 0, la, 1, 1, 0, ra);
      #1 chk("R2 no change before edge", 6'b000100);
      tick();
      chk("R5 earlier arrival holds", {lb, 1'b0, ~lb, 1'b1, 2'b00});
      tick();
      chk("R6 holder keeps word", {lb, 1'b0, ~lb, 1'b1, 2'b00});
      drv(1, 1, 0, la, 0, 0, 0, ra);
      tick();
      chk("R7 release clears busy", 6'b001000);
    end

    // Sweep C: left first, right joins, left moves to next address (R5 R7)
    for (int a = 0; a < NA * NA; a++) begin
      logic [AW-1:0] la, ra, ln;
      logic rb, lb2;
      la = a[AW-1:0]; ra = a[2*AW-1:AW]; ln = la + 1'b1;
      rb = (la == ra); lb2 = (ln == ra);
      drv(0, 0, 0, '0, 0, 0, 0, '0);
      tick();
      drv(1, 1, 0, la, 0, 0, 0, '0);
      tick();
      drv(1, 1, 0, la, 1, 1, 0, ra);
      tick();
      chk("R5 left held first", {1'b0, rb, 1'b1, ~rb, 2'b00});
      drv(1, 1, 0, ln, 1, 1, 0, ra);
      tick();
      chk("R7 holder moved away", {lb2, 1'b0, ~lb2, 1'b1, 2'b00});
    end

    // Sweep D: slave mode obeys external BUSY on a colliding pair (R9)
    master_mode = 1'b0;
    for (int b = 0; b < 4; b++) begin
      drv(0, 0, 0, '0, 0, 0, 0, '0);
      l_busy_in = 0; r_busy_in = 0;
      tick();
      drv(1, 1, 0, 2'd1, 1, 1, 0, 2'd1);
      l_busy_in = b[0]; r_busy_in = b[1];
      tick();
      chk("R9 slave follows external busy",
          {b[0], b[1], ~b[0], ~b[1], 2'b00});
    end

    // Slave mode with reads and external busy: drive unaffected (R11)
    drv(1, 0, 1, 2'd2, 1, 0, 1, 2'd2);
    l_busy_in = 1; r_busy_in = 1;
    tick();
    chk("R11 read drive ignores busy", 6'b110011);

    finish_run();
  end
endmodule